// File: doc/BRIEF.md
# Multiplexer-Based Serial Transmitter

This block sends one byte at a time as an asynchronous serial frame on a single line. It does not shift the frame out of a wide register. It keeps the byte in one holding register and steps a small slot counter. The counter's value picks, through a multiplexer, the level that the line carries in that slot. The counter reads zero only when the block is idle, so the same zero test serves as the ready flag for the logic that feeds the transmitter.

A client waits for `ready`, puts a byte on `data` and a format code on `mode`, and raises `send`. On that rising edge the byte and the format code are captured, so both inputs may change on the next clock. The frame then advances one slot on each `baud_tick` pulse. `baud_tick` is a single-clock enable at the line rate and is produced outside this block. The format code chooses between no parity and four kinds of parity bit.

Top module: `mux_uart_tx`

## Requirements
- R1: After synchronous reset, `ready` is 1 and `txd` is 1. While the block stays idle, `txd` stays 1.
- R2: A frame starts only on a rising edge of `send` seen while `ready` is 1. `ready` drops at the clock edge that sees the edge. A `send` held high through reset, or held high from before a frame ends, starts nothing.
- R3: While busy, the slot counter moves only on a clock where `baud_tick` is 1. A `baud_tick` while idle changes neither `ready` nor `txd`.
- R4: Slot order runs from 1 to 14. Slots 1 and 2 are high, slot 3 is the low start bit, slots 4 to 11 carry data bits 0 to 7 (LSB first), slot 12 is the parity slot, and slots 13 and 14 are high. `txd` shows a slot's level from the clock after the counter enters that slot. The tick taken in slot 14 sets `ready` back to 1 at that same edge.
- R5: When `mode[2]` is 0, the parity slot is 1, which gives a 10-bit frame of start, data and stop that is followed by mark level.
- R6: `mode` = 3'b100 puts 0 (space) in the parity slot. `mode` = 3'b101 puts 1 (mark) there.
- R7: `mode` = 3'b110 puts the XOR of the eight data bits in the parity slot (even parity). `mode` = 3'b111 puts its inverse there (odd parity).
- R8: Data and mode are taken from the inputs at the starting edge. Changes on `data` or `mode` during a frame do not alter it.
- R9: A rising edge of `send` while busy is ignored. The frame in progress continues unchanged and no second frame follows.
- R10: The slot counter never exceeds 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_tick | input | 1 | One-clock enable per bit period |
| send | input | 1 | Start request; its rising edge is used |
| data | input | 8 | Byte to transmit |
| mode | input | 3 | Format code: bit 2 enables parity, bits 1:0 select space/mark/even/odd |
| ready | output | 1 | 1 when idle and able to accept a byte |
| txd | output | 1 | Serial line, idle high |

## Verification
The bench sends every byte under every one of the eight format codes. It checks each slot of each frame, so a reversed bit order, an off-by-one slot index or a swapped even/odd parity shows up as a wrong level in a specific slot. In every frame the bench scrambles `data` and `mode` right after the start. It also raises `send` again in the middle of the frame. A design that reads the live inputs, or that restarts on a busy edge, therefore sends wrong bits or starts an extra frame. Directed cases hold `send` high through reset and across the end of a frame, which exposes level-triggered starting in place of edge-triggered starting. Extra clocks without `baud_tick` catch a counter that runs on the system clock.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

  // Slot positions that are fixed by the frame layout
  localparam int SLOT_PRE_LAST = 2;   // slots 1..2 hold mark level
  localparam int SLOT_START    = 3;
  localparam int SLOT_DATA0    = 4;

  // Meaning of the low two format bits when parity is enabled
  typedef enum logic [1:0] {
    PAR_SPACE = 2'b00,
    PAR_MARK  = 2'b01,
    PAR_EVEN  = 2'b10,
    PAR_ODD   = 2'b11
  } par_kind_e;

  // Level driven in the parity slot
  function automatic logic parity_level(input logic [2:0] fmt, input logic xor_all);
    logic lvl;
    if (!fmt[2]) begin
      lvl = 1'b1;
    end else begin
      case (par_kind_e'(fmt[1:0]))
        PAR_SPACE: lvl = 1'b0;
        PAR_MARK:  lvl = 1'b1;
        PAR_EVEN:  lvl = xor_all;
        default:   lvl = ~xor_all;
      endcase
    end
    return lvl;
  endfunction

endpackage

// File: rtl/mtx_edge.sv
module mtx_edge (
  input  logic clk,
  input  logic send,
  output logic rise
);

  logic send_q;

  // Sampled every cycle, reset included, so a level held through reset is no edge
  always_ff @(posedge clk) begin
    send_q <= send;
  end

  assign rise = send & ~send_q;

endmodule

// File: rtl/mtx_bitpos.sv
module mtx_bitpos #(
  parameter int LAST  = 14,
  parameter int POS_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             tick,
  output logic [POS_W-1:0] pos
);

  localparam logic [POS_W-1:0] LAST_V = POS_W'(LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
    end else if (pos == '0) begin
      if (start) pos <= POS_W'(1);
    end else if (tick) begin
      pos <= (pos == LAST_V) ? '0 : pos + POS_W'(1);
    end
  end

endmodule

// File: rtl/mtx_bitmux.sv
module mtx_bitmux #(
  parameter int DATA_W = 8,
  parameter int POS_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  logic [2:0]        mode,
  input  logic [POS_W-1:0]  pos,
  output logic              txd
);
  import mtx_pkg::*;

  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [POS_W-1:0] START_V = POS_W'(SLOT_START);
  localparam logic [POS_W-1:0] D0_V    = POS_W'(SLOT_DATA0);
  localparam logic [POS_W-1:0] PAR_V   = POS_W'(SLOT_DATA0 + DATA_W);

  logic [DATA_W-1:0] byte_q;
  logic [2:0]        fmt_q;
  logic [POS_W-1:0]  off;
  logic              slot_lvl;

  assign off = pos - D0_V;

  always_comb begin
    if (pos == START_V)
      slot_lvl = 1'b0;
    else if (pos >= D0_V && pos < PAR_V)
      slot_lvl = byte_q[off[IDX_W-1:0]];
    else if (pos == PAR_V)
      slot_lvl = parity_level(fmt_q, ^byte_q);
    else
      slot_lvl = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_q <= '0;
      fmt_q  <= '0;
      txd    <= 1'b1;
    end else begin
      if (load) begin
        byte_q <= data;
        fmt_q  <= mode;
      end
      txd <= slot_lvl;
    end
  end

endmodule

// File: rtl/mux_uart_tx.sv
module mux_uart_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              send,
  input  logic [DATA_W-1:0] data,
  input  logic [2:0]        mode,
  output logic              ready,
  output logic              txd
);
  import mtx_pkg::*;

  localparam int LAST  = SLOT_DATA0 + DATA_W + 2;
  localparam int POS_W = $clog2(LAST + 1);

  logic             rise;
  logic             start;
  logic [POS_W-1:0] pos;

  mtx_edge u_edge (
    .clk  (clk),
    .send (send),
    .rise (rise)
  );

  assign ready = (pos == '0);
  assign start = rise & ready;

  mtx_bitpos #(.LAST(LAST), .POS_W(POS_W)) u_pos (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .tick  (baud_tick),
    .pos   (pos)
  );

  mtx_bitmux #(.DATA_W(DATA_W), .POS_W(POS_W)) u_mux (
    .clk  (clk),
    .rst  (rst),
    .load (start),
    .data (data),
    .mode (mode),
    .pos  (pos),
    .txd  (txd)
  );

endmodule

// File: rtl/mtx_chk.sv
module mtx_chk #(
  parameter int LAST  = 14,
  parameter int POS_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             baud_tick,
  input logic             send,
  input logic             ready,
  input logic             txd,
  input logic [POS_W-1:0] pos
);

  // R1
  idle_mark_chk: assert property (@(posedge clk) disable iff (rst)
    ready && $past(ready) |-> txd);

  // R2
  start_chk: assert property (@(posedge clk) disable iff (rst)
    ready && send && !$past(send) |=> !ready);

  // R2
  idle_stay_chk: assert property (@(posedge clk) disable iff (rst)
    ready && !(send && !$past(send)) |=> ready);

  // R3
  hold_pos_chk: assert property (@(posedge clk) disable iff (rst)
    !ready && !baud_tick |=> $stable(pos));

  // R4
  frame_end_chk: assert property (@(posedge clk) disable iff (rst)
    baud_tick && pos == POS_W'(LAST) |=> ready);

  // R10
  pos_range_chk: assert property (@(posedge clk) disable iff (rst)
    pos <= POS_W'(LAST));

endmodule

bind mux_uart_tx mtx_chk #(.LAST(LAST), .POS_W(POS_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .baud_tick (baud_tick),
  .send      (send),
  .ready     (ready),
  .txd       (txd),
  .pos       (pos)
);

// File: tb/sim_mux_uart_tx.sv
`timescale 1ns/1ps
module sim_mux_uart_tx;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0;
  logic       send = 1'b0;
  logic [7:0] data = 8'h00;
  logic [2:0] mode = 3'b000;
  logic       ready;
  logic       txd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mux_uart_tx #(.DATA_W(8)) u0 (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .send(send),
    .data(data), .mode(mode), .ready(ready), .txd(txd)
  );

  task automatic chk(input int got, input int exp, input string tag);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0d expected=%0d t=%0t", tag, got, exp, $time);
    end
  endtask

  // Expected level of slot s for byte d and format m
  function automatic int exp_bit(input int s, input logic [7:0] d, input logic [2:0] m);
    int x;
    x = ^d;
    if (s == 3) return 0;
    if (s >= 4 && s <= 11) return int'(d[s-4]);
    if (s == 12) begin
      if (!m[2]) return 1;
      case (m[1:0])
        2'b00: return 0;
        2'b01: return 1;
        2'b10: return x;
        default: return 1 - x;
      endcase
    end
    return 1;
  endfunction

  function automatic string slot_tag(input int s, input logic [2:0] m);
    if (s != 12) return "R4 slot";
    if (!m[2]) return "R5 parity slot";
    if (!m[1]) return "R6 parity slot";
    return "R7 parity slot";
  endfunction

  // One full frame; hold keeps send high from mid-frame past the end
  task automatic run_frame(input logic [7:0] d, input logic [2:0] m, input bit hold);
    chk(int'(ready), 1, "R2 ready before start");
    data = d; mode = m; send = 1'b1;
    @(negedge clk);
    chk(int'(ready), 0, "R2 ready drops on start edge");
    send = 1'b0; data = ~d; mode = ~m;          // R8 scramble after capture
    @(negedge clk);
    for (int s = 1; s <= 14; s++) begin
      chk(int'(txd), exp_bit(s, d, m), $sformatf("%s %0d d=%02h m=%0d R8", slot_tag(s, m), s, d, m));
      if (s == 6) begin send = 1'b1; data = d ^ 8'h5A; mode = m ^ 3'b011; end  // R9 busy edge
      if (s == 7 && !hold) send = 1'b0;
      if (s == 9) begin
        @(negedge clk);                          // R3 no tick, no movement
        chk(int'(txd), exp_bit(9, d, m), "R3 slot held without tick");
        chk(int'(ready), 0, "R3 busy held without tick");
      end
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
      if (s == 14) chk(int'(ready), 1, "R4 ready after last slot");
      @(negedge clk);
    end
    chk(int'(txd), 1, "R1 line idle after frame");
    chk(int'(ready), 1, "R9 no second frame");
  endtask

  initial begin
    // R2: send held high through reset
    send = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(int'(ready), 1, "R1 ready after reset");
    chk(int'(txd), 1, "R1 txd after reset");
    for (int k = 0; k < 3; k++) begin
      baud_tick = 1'b1; @(negedge clk); baud_tick = 1'b0; @(negedge clk);
      chk(int'(ready), 1, "R2 held send through reset starts nothing");
      chk(int'(txd), 1, "R3 idle tick leaves txd high");
    end
    send = 1'b0;
    @(negedge clk);

    for (int m = 0; m < 8; m++)
      for (int d = 0; d < 256; d++)
        run_frame(8'(d), 3'(m), 1'b0);

    // R2: send held across frame end does not retrigger
    run_frame(8'hC3, 3'b111, 1'b1);
    for (int k = 0; k < 4; k++) begin
      baud_tick = 1'b1; @(negedge clk); baud_tick = 1'b0; @(negedge clk);
      chk(int'(ready), 1, "R2 held send after frame starts nothing");
      chk(int'(txd), 1, "R2 line stays idle");
    end
    send = 1'b0;
    @(negedge clk);
    run_frame(8'h01, 3'b110, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule